// File: doc/BRIEF.md
# DMA Beat Byte-Order and Store Command Formatter

This block sits between the DMA master port of a host controller and the cache-side request interface. Each 64-bit beat, read or write, passes through one register stage. On the way its bytes are reordered by one of four permutations. Its address is extended to 40 bits, and its command qualifier bits are set for the cache.

The block holds two 2-bit permutation selectors, one for buffer beats and one for descriptor beats, so the two traffic classes can use different byte orders. The same permutation applies to reads and writes.

When wide addressing is off, the top address byte comes from a configuration field. Stores get a commit flag from a control chosen by traffic class. Zero-page and store-type flags come from their own controls.

Beats marked as 32-bit register accesses bypass the permutation, carry no qualifiers, and may have address bit 2 inverted. The configuration inputs are static while beats are in flight.

Top module: `dbf_fmt_top`

## Requirements
- R1: Byte lanes are named A (bits 63:56) through H (bits 7:0). Selector value 0 passes the data unchanged as A-B-C-D-E-F-G-H.
- R2: Selector value 1 reverses all eight bytes, giving H-G-F-E-D-C-B-A.
- R3: Selector value 2 reverses the bytes inside each 32-bit half, giving D-C-B-A-H-G-F-E.
- R4: Selector value 3 exchanges the two 32-bit halves, giving E-F-G-H-A-B-C-D.
- R5: A beat with `in_desc_i`=1 uses `cfg_desc_mode_i`. A beat with `in_desc_i`=0 uses `cfg_buf_mode_i`.
- R6: For non-register beats with `cfg_wide_addr_i`=0, output address bits 39:32 equal `cfg_addr_hi_i` and bits 31:0 come from the request. With `cfg_wide_addr_i`=1 all 40 bits come from the request.
- R7: `out_commit_o` is 1 only on store beats (`in_write_i`=1). It equals `cfg_desc_commit_i` for descriptor stores and `cfg_buf_commit_i` for buffer stores.
- R8: `out_zero_page_o` and `out_store_type_o` equal `cfg_zero_page_i` and `cfg_store_type_i` on store beats, and are 0 on read beats.
- R9: A beat with `in_reg_i`=1 has its data passed unchanged and all three qualifiers at 0. Its 40-bit address is passed unchanged except that bit 2 is inverted when `cfg_flip_a2_i`=1.
- R10: An accepted beat appears at the output on the next cycle. `in_ready_o` is 1 when the output is empty or being taken. While `out_valid_o`=1 and `out_ready_i`=0 the output holds stable. Every accepted beat leaves exactly once, in order.
- R11: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R12: Read beats (`in_write_i`=0) receive the same permutation as write beats of the same class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_buf_mode_i | input | 2 | Byte permutation for buffer beats |
| cfg_desc_mode_i | input | 2 | Byte permutation for descriptor beats |
| cfg_wide_addr_i | input | 1 | 1: request supplies all address bits |
| cfg_addr_hi_i | input | 8 | Upper address byte used when wide addressing is off |
| cfg_desc_commit_i | input | 1 | Commit flag for descriptor stores |
| cfg_buf_commit_i | input | 1 | Commit flag for buffer stores |
| cfg_zero_page_i | input | 1 | Zero-page flag for stores |
| cfg_store_type_i | input | 1 | Store-type flag for stores |
| cfg_flip_a2_i | input | 1 | Invert address bit 2 on register accesses |
| in_valid_i | input | 1 | Beat offered |
| in_ready_o | output | 1 | Beat accepted when high with valid |
| in_write_i | input | 1 | 1: store, 0: read |
| in_desc_i | input | 1 | 1: descriptor, 0: buffer |
| in_reg_i | input | 1 | 32-bit register access |
| in_addr_i | input | 40 | Request address |
| in_data_i | input | 64 | Beat data |
| out_valid_o | output | 1 | Formatted beat present |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_write_o | output | 1 | Store flag |
| out_reg_o | output | 1 | Register access flag |
| out_addr_o | output | 40 | Formed address |
| out_data_o | output | 64 | Permuted data |
| out_commit_o | output | 1 | Commit qualifier |
| out_zero_page_o | output | 1 | Zero-page qualifier |
| out_store_type_o | output | 1 | Store-type qualifier |

## Verification
The output stall and the arrival of a new beat can fall in the same cycle. Random `out_ready_i` drops while beats are being offered make this happen often. The question is whether the held beat stays untouched and the new one is accepted only when the stage empties.

The bench keeps a queue of expected beats, computed from the requirements at the moment each beat is accepted. It checks the held values on every stalled cycle and matches each departing beat against the head of the queue. This catches lost or doubled beats as well as wrong permutation, address or qualifier values.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    SWAP_NONE    = 2'd0,
    SWAP_ALL     = 2'd1,
    SWAP_IN_HALF = 2'd2,
    SWAP_HALVES  = 2'd3
  } swap_mode_e;

  typedef struct packed {
    logic commit;
    logic zero_page;
    logic store_type;
  } store_qual_t;

  localparam int QUAL_W = $bits(store_qual_t);
endpackage

// File: rtl/dbf_byte_permute.sv
module dbf_byte_permute #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int HALF  = BYTES / 2;

  logic [7:0] lane_in [BYTES];

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    // lane 0 is the most significant byte
    localparam int SRC_ALL  = BYTES - 1 - k;
    localparam int SRC_HREV = (k / HALF) * HALF + HALF - 1 - (k % HALF);
    localparam int SRC_HSWP = (k + HALF) % BYTES;

    logic [3:0][7:0] cand;

    assign lane_in[k] = data_i[DATA_W-1-8*k -: 8];
    assign cand = {lane_in[SRC_HSWP], lane_in[SRC_HREV], lane_in[SRC_ALL], lane_in[k]};
    assign data_o[DATA_W-1-8*k -: 8] = cand[mode_i];
  end
endmodule

// File: rtl/dbf_addr_form.sv
module dbf_addr_form #(
  parameter int ADDR_W = 40,
  parameter int HI_W   = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_i,
  input  logic              wide_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic              flip_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LOW_W = ADDR_W - HI_W;

  logic [HI_W-1:0]  hi;
  logic [LOW_W-1:0] low;

  always_comb begin
    hi  = (wide_i || reg_i) ? addr_i[ADDR_W-1:LOW_W] : hi_i;
    low = addr_i[LOW_W-1:0];
    low[2] = addr_i[2] ^ (reg_i & flip_i);
  end

  assign addr_o = {hi, low};
endmodule

// File: rtl/dbf_qual_gen.sv
module dbf_qual_gen
  import dbf_pkg::*;
(
  input  logic        write_i,
  input  logic        desc_i,
  input  logic        reg_i,
  input  logic        desc_commit_i,
  input  logic        buf_commit_i,
  input  logic        zero_page_i,
  input  logic        store_type_i,
  output store_qual_t qual_o
);
  logic cache_store;

  assign cache_store       = write_i & ~reg_i;
  assign qual_o.commit     = cache_store & (desc_i ? desc_commit_i : buf_commit_i);
  assign qual_o.zero_page  = cache_store & zero_page_i;
  assign qual_o.store_type = cache_store & store_type_i;
endmodule

// File: rtl/dbf_out_stage.sv
module dbf_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_pay_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_pay_o
);
  logic         valid_q;
  logic [W-1:0] pay_q;

  assign in_ready_o = ~valid_q | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pay_q   <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) pay_q <= in_pay_i;
    end
  end

  assign out_valid_o = valid_q;
  assign out_pay_o   = pay_q;
endmodule

// File: rtl/dbf_fmt_top.sv
module dbf_fmt_top
  import dbf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 40,
  parameter int HI_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_buf_mode_i,
  input  logic [1:0]        cfg_desc_mode_i,
  input  logic              cfg_wide_addr_i,
  input  logic [HI_W-1:0]   cfg_addr_hi_i,
  input  logic              cfg_desc_commit_i,
  input  logic              cfg_buf_commit_i,
  input  logic              cfg_zero_page_i,
  input  logic              cfg_store_type_i,
  input  logic              cfg_flip_a2_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_write_i,
  input  logic              in_desc_i,
  input  logic              in_reg_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_write_o,
  output logic              out_reg_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_commit_o,
  output logic              out_zero_page_o,
  output logic              out_store_type_o
);
  localparam int PAY_W = 2 + QUAL_W + ADDR_W + DATA_W;

  swap_mode_e        mode_sel;
  logic [DATA_W-1:0] data_fmt;
  logic [ADDR_W-1:0] addr_fmt;
  store_qual_t       qual_fmt;
  store_qual_t       qual_q;
  logic [PAY_W-1:0]  pay_d;
  logic [PAY_W-1:0]  pay_q;

  // register accesses never reorder bytes
  always_comb begin
    if (in_reg_i)       mode_sel = SWAP_NONE;
    else if (in_desc_i) mode_sel = swap_mode_e'(cfg_desc_mode_i);
    else                mode_sel = swap_mode_e'(cfg_buf_mode_i);
  end

  dbf_byte_permute #(.DATA_W(DATA_W)) i_permute (
    .data_i (in_data_i),
    .mode_i (mode_sel),
    .data_o (data_fmt)
  );

  dbf_addr_form #(.ADDR_W(ADDR_W), .HI_W(HI_W)) i_addr (
    .addr_i (in_addr_i),
    .reg_i  (in_reg_i),
    .wide_i (cfg_wide_addr_i),
    .hi_i   (cfg_addr_hi_i),
    .flip_i (cfg_flip_a2_i),
    .addr_o (addr_fmt)
  );

  dbf_qual_gen i_qual (
    .write_i       (in_write_i),
    .desc_i        (in_desc_i),
    .reg_i         (in_reg_i),
    .desc_commit_i (cfg_desc_commit_i),
    .buf_commit_i  (cfg_buf_commit_i),
    .zero_page_i   (cfg_zero_page_i),
    .store_type_i  (cfg_store_type_i),
    .qual_o        (qual_fmt)
  );

  assign pay_d = {in_write_i, in_reg_i, qual_fmt, addr_fmt, data_fmt};

  dbf_out_stage #(.W(PAY_W)) i_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_pay_i    (pay_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_pay_o   (pay_q)
  );

  assign {out_write_o, out_reg_o, qual_q, out_addr_o, out_data_o} = pay_q;
  assign out_commit_o     = qual_q.commit;
  assign out_zero_page_o  = qual_q.zero_page;
  assign out_store_type_o = qual_q.store_type;
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 40,
  parameter int HI_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_reg_i,
  input logic              in_desc_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic [1:0]        cfg_buf_mode_i,
  input logic [1:0]        cfg_desc_mode_i,
  input logic              cfg_wide_addr_i,
  input logic [HI_W-1:0]   cfg_addr_hi_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_write_o,
  input logic              out_reg_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_commit_o,
  input logic              out_zero_page_o,
  input logic              out_store_type_o
);
  logic [1:0] sel_mode;
  assign sel_mode = in_desc_i ? cfg_desc_mode_i : cfg_buf_mode_i;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_addr_o) && $stable(out_write_o) && $stable(out_reg_o));

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_read_qual_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_write_o |-> !out_commit_o && !out_zero_page_o && !out_store_type_o);

  assert_reg_qual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_reg_o |-> !out_commit_o && !out_zero_page_o && !out_store_type_o);

  assert_addr_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_reg_o && !cfg_wide_addr_i |-> out_addr_o[ADDR_W-1 -: HI_W] == cfg_addr_hi_i);

  assert_identity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_reg_i || sel_mode == 2'd0) |=> out_data_o == $past(in_data_i));
endmodule

bind dbf_fmt_top dbf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HI_W(HI_W)) i_dbf_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .in_valid_i       (in_valid_i),
  .in_ready_o       (in_ready_o),
  .in_reg_i         (in_reg_i),
  .in_desc_i        (in_desc_i),
  .in_data_i        (in_data_i),
  .cfg_buf_mode_i   (cfg_buf_mode_i),
  .cfg_desc_mode_i  (cfg_desc_mode_i),
  .cfg_wide_addr_i  (cfg_wide_addr_i),
  .cfg_addr_hi_i    (cfg_addr_hi_i),
  .out_valid_o      (out_valid_o),
  .out_ready_i      (out_ready_i),
  .out_write_o      (out_write_o),
  .out_reg_o        (out_reg_o),
  .out_addr_o       (out_addr_o),
  .out_data_o       (out_data_o),
  .out_commit_o     (out_commit_o),
  .out_zero_page_o  (out_zero_page_o),
  .out_store_type_o (out_store_type_o)
);

// File: tb/test_dbf_fmt_top.sv
`timescale 1ns/1ps
module test_dbf_fmt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_buf_mode_i = '0;
  logic [1:0]  cfg_desc_mode_i = '0;
  logic        cfg_wide_addr_i = 1'b0;
  logic [7:0]  cfg_addr_hi_i = '0;
  logic        cfg_desc_commit_i = 1'b0;
  logic        cfg_buf_commit_i = 1'b0;
  logic        cfg_zero_page_i = 1'b0;
  logic        cfg_store_type_i = 1'b0;
  logic        cfg_flip_a2_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        in_write_i = 1'b0;
  logic        in_desc_i = 1'b0;
  logic        in_reg_i = 1'b0;
  logic [39:0] in_addr_i = '0;
  logic [63:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        out_write_o;
  logic        out_reg_o;
  logic [39:0] out_addr_o;
  logic [63:0] out_data_o;
  logic        out_commit_o;
  logic        out_zero_page_o;
  logic        out_store_type_o;

  always #2 clk_i = ~clk_i;

  dbf_fmt_top i_dbf_fmt_top (.*);

  typedef struct {
    logic        w;
    logic        r;
    logic        c;
    logic        z;
    logic        s;
    logic [39:0] a;
    logic [63:0] d;
    string       dtag;
    string       atag;
    string       ctag;
  } exp_t;

  exp_t        sbq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  bit          hold_pend = 0;
  logic [63:0] hold_d;
  logic [39:0] hold_a;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] perm(logic [63:0] d, logic [1:0] m);
    case (m)
      2'd0: return d;
      2'd1: return {d[7:0], d[15:8], d[23:16], d[31:24], d[39:32], d[47:40], d[55:48], d[63:56]};
      2'd2: return {d[39:32], d[47:40], d[55:48], d[63:56], d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return {d[31:0], d[63:32]};
    endcase
  endfunction

  function automatic exp_t make_exp(bit w, bit ds, bit rg, logic [39:0] a, logic [63:0] d);
    exp_t e;
    logic [1:0] m;
    m = ds ? cfg_desc_mode_i : cfg_buf_mode_i;
    e.w = w;
    e.r = rg;
    if (rg) begin
      e.d = d;
      e.a = a ^ (40'(cfg_flip_a2_i) << 2);
      e.c = 0; e.z = 0; e.s = 0;
      e.dtag = "R9 data"; e.atag = "R9 addr"; e.ctag = "R9 qual";
    end else begin
      e.d = perm(d, m);
      e.a = cfg_wide_addr_i ? a : {cfg_addr_hi_i, a[31:0]};
      e.c = w && (ds ? cfg_desc_commit_i : cfg_buf_commit_i);
      e.z = w && cfg_zero_page_i;
      e.s = w && cfg_store_type_i;
      case (m)
        2'd0: e.dtag = "R1";
        2'd1: e.dtag = "R2";
        2'd2: e.dtag = "R3";
        default: e.dtag = "R4";
      endcase
      e.dtag = {e.dtag, ds ? " R5 desc" : " R5 buf", w ? "" : " R12 read"};
      e.atag = "R6 addr";
      e.ctag = w ? "R7 R8 store qual" : "R8 read qual";
    end
    return e;
  endfunction

  task automatic step(bit v, bit w, bit ds, bit rg, logic [39:0] a, logic [63:0] d,
                      bit ordy, output bit acc);
    exp_t e;
    @(negedge clk_i);
    in_valid_i = v; in_write_i = w; in_desc_i = ds; in_reg_i = rg;
    in_addr_i = a; in_data_i = d; out_ready_i = ordy;
    #1;
    if (hold_pend) begin
      check("R10 hold valid", 64'(out_valid_o), 64'd1);
      check("R10 hold data", out_data_o, hold_d);
      check("R10 hold addr", 64'(out_addr_o), 64'(hold_a));
    end
    hold_pend = out_valid_o && !out_ready_i;
    hold_d = out_data_o;
    hold_a = out_addr_o;
    check("R10 ready rule", 64'(in_ready_o), 64'(!out_valid_o || out_ready_i));
    if (out_valid_o && out_ready_i) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 extra beat actual=%h expected=none", out_data_o);
      end else begin
        e = sbq.pop_front();
        check(e.dtag, out_data_o, e.d);
        check(e.atag, 64'(out_addr_o), 64'(e.a));
        check(e.ctag, {61'd0, out_commit_o, out_zero_page_o, out_store_type_o}, {61'd0, e.c, e.z, e.s});
        check("R10 kind", {62'd0, out_write_o, out_reg_o}, {62'd0, e.w, e.r});
      end
    end
    acc = v && in_ready_o;
    if (acc) sbq.push_back(make_exp(w, ds, rg, a, d));
  endtask

  task automatic send(bit w, bit ds, bit rg, logic [39:0] a, logic [63:0] d);
    bit acc;
    acc = 0;
    for (int t = 0; t < 50 && !acc; t++) step(1, w, ds, rg, a, d, 1, acc);
  endtask

  task automatic drain();
    bit acc;
    for (int t = 0; t < 20 && (out_valid_o || sbq.size() != 0); t++)
      step(0, 0, 0, 0, '0, '0, 1, acc);
    check("R10 all beats delivered", 64'(sbq.size()), 64'd0);
  endtask

  localparam logic [63:0] PAT = 64'h0011_2233_4455_6677;

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R11 out_valid after reset", 64'(out_valid_o), 64'd0);
    rst_ni = 1'b1;
    #1;
    check("R11 in_ready after reset", 64'(in_ready_o), 64'd1);

    // each mode on each class, buffer and descriptor set to differ
    for (int m = 0; m < 4; m++) begin
      drain();
      cfg_buf_mode_i = 2'(m); cfg_desc_mode_i = 2'(3 - m);
      cfg_wide_addr_i = 1; cfg_buf_commit_i = 1; cfg_desc_commit_i = 0;
      cfg_zero_page_i = m[0]; cfg_store_type_i = m[1];
      send(1, 0, 0, 40'h12_3456_7890, PAT);
      send(1, 1, 0, 40'h12_3456_7898, PAT);
      send(0, 0, 0, 40'h00_0000_1000, PAT);
      send(0, 1, 0, 40'h00_0000_1008, PAT);
    end
    drain();

    // narrow addressing and swapped commit controls
    cfg_wide_addr_i = 0; cfg_addr_hi_i = 8'hA5;
    cfg_buf_commit_i = 0; cfg_desc_commit_i = 1;
    send(1, 0, 0, 40'hFF_DEAD_BEE8, 64'h0102_0304_0506_0708);
    send(1, 1, 0, 40'h3C_0000_0010, 64'h8877_6655_4433_2211);
    drain();

    // register accesses, flip off then on, both bit-2 values
    for (int f = 0; f < 2; f++) begin
      cfg_flip_a2_i = f[0];
      send(1, 0, 1, 40'h77_0000_0100, 64'hCAFE_F00D_1234_5678);
      send(0, 1, 1, 40'h77_0000_0104, 64'hFEED_FACE_0BAD_BEEF);
      drain();
    end

    // random traffic with backpressure, config changed between batches
    for (int b = 0; b < 20; b++) begin
      bit have;
      bit pw, pd, pr, acc;
      logic [39:0] pa;
      logic [63:0] pdat;
      drain();
      cfg_buf_mode_i = 2'($urandom); cfg_desc_mode_i = 2'($urandom);
      cfg_wide_addr_i = 1'($urandom); cfg_addr_hi_i = 8'($urandom);
      cfg_desc_commit_i = 1'($urandom); cfg_buf_commit_i = 1'($urandom);
      cfg_zero_page_i = 1'($urandom); cfg_store_type_i = 1'($urandom);
      cfg_flip_a2_i = 1'($urandom);
      have = 0;
      for (int i = 0; i < 150; i++) begin
        bit v;
        if (!have) begin
          pw = 1'($urandom); pd = 1'($urandom); pr = ($urandom % 6) == 0;
          pa = {8'($urandom), 32'($urandom)};
          pdat = {32'($urandom), 32'($urandom)};
        end
        v = have || (($urandom % 4) != 0);
        have = v;
        step(v, pw, pd, pr, pa, pdat, ($urandom % 3) != 0, acc);
        if (acc) have = 0;
      end
      // finish an offered beat so valid is never withdrawn
      if (have) send(pw, pd, pr, pa, pdat);
    end
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule